// File: doc/BRIEF.md
# Line Pixel FIR with Exact Accumulation and Clamped Output

This block filters one colour channel of a video line with a short one-dimensional kernel of programmable weights. Pixels arrive one per beat on a valid/ready stream. A flag on the last pixel marks the end of each line. Every pixel produces exactly one filtered pixel on a matching output stream, and the line-end flag comes out on the filtered pixel that corresponds to the last input pixel.

Inside the block, every product and the running sum are kept at full width, so no bit is lost before the final step. That step first rounds half up to the chosen number of kept fraction bits. It then clamps the result into the unsigned output range.

Weights are written one at a time through a small write port into a staging set. The staging set is copied into the working set when the next line begins, so a line is never filtered with a mix of old and new weights. Input pixels can optionally be clamped into a guard window before filtering. Where the kernel reaches past either end of a line, the nearest edge pixel is repeated to fill the missing taps.

Top module: `pix_fir`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1, and all working weights are zero.
- R2: With guard clamping enabled (default window 16..235), an input below the lower bound is filtered as the lower bound, and an input above the upper bound is filtered as the upper bound.
- R3: For a line of N pixels x[0..N-1], output i equals the requantised value of the sum over k of w[k]·x[i+H−k], where H=(TAPS−1)/2 and weight index k is the `coef_idx` value it was written at. Weights are two's complement when `COEF_SIGNED`=1, and carry `COEF_FRAC` fraction bits (default 6, so 64 means 1.0). No precision is lost before requantisation.
- R4: A pixel position below 0 reads x[0], and a position above N−1 reads x[N−1]. This holds for every line length, including lines of length 1 and lines shorter than the kernel.
- R5: Requantisation adds 2^(D−1) and then shifts right arithmetically by D, where D=`COEF_FRAC`−`OUT_FRAC`. An exact half therefore rounds toward plus infinity.
- R6: A rounded result below zero is output as 0.
- R7: A rounded result above 2^`OUT_W`−1 is output as 2^`OUT_W`−1.
- R8: Each line yields exactly as many outputs as it has inputs, in order. `out_eol` is 1 only on the last one. After a line-end pixel is accepted, `in_ready` is 0 on the next cycle, while the line tail is flushed.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_eol` hold. Output stalls lose or duplicate no pixel.
- R10: A weight written while a line is in progress affects only lines that start after the write. The line already in progress finishes with the weights that were active at its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel present |
| in_data | input | IN_W | Unsigned input pixel |
| in_eol | input | 1 | Input pixel is the last of its line |
| in_ready | output | 1 | Block accepts an input pixel this cycle |
| out_valid | output | 1 | Output pixel present |
| out_data | output | OUT_W | Unsigned filtered pixel |
| out_eol | output | 1 | Output pixel is the last of its line |
| out_ready | input | 1 | Downstream accepts the output pixel |
| coef_wr | input | 1 | Write strobe for one staged weight |
| coef_idx | input | $clog2(TAPS) | Tap index of the staged weight |
| coef_val | input | COEF_W | Weight value |

## Verification
The hardest situation to reach is the line tail. The last few outputs of a line are produced after input has closed, and they draw on repeated edge pixels. At the same time, the output may be stalled, and a weight update may be waiting for the next line. The stimulus sends lines of length 1, 2, 3 and longer under one-sided kernels, so any replication mistake shows directly in the output. It holds `out_ready` low on a pseudo-random pattern throughout the long sweeps. It also writes a new weight set in the middle of a line and checks that the old set governs the entire line, including its flushed tail.

// File: rtl/pxfir_pkg.sv
package pxfir_pkg;

    typedef enum logic [1:0] {
        WIN_IDLE,
        WIN_RUN,
        WIN_DRAIN
    } win_state_e;

    typedef struct packed {
        logic v;
        logic eol;
    } beat_tag_t;

    function automatic int half_span(input int taps);
        return (taps - 1) / 2;
    endfunction

    function automatic int acc_width(input int in_w, input int coef_w, input int taps);
        return in_w + coef_w + $clog2(taps) + 1;
    endfunction

endpackage

// File: rtl/pxfir_coef_bank.sv
module pxfir_coef_bank #(
    parameter int TAPS   = 5,
    parameter int COEF_W = 10,
    parameter int IDX_W  = 3
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr,
    input  logic [IDX_W-1:0]               idx,
    input  logic [COEF_W-1:0]              val,
    input  logic                           apply,
    output logic [TAPS-1:0][COEF_W-1:0]    act
);

    logic [TAPS-1:0][COEF_W-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            act     <= '0;
        end else begin
            if (wr && (int'(idx) < TAPS)) begin
                stage_q[idx] <= val;
            end
            if (apply) begin
                act <= stage_q;
            end
        end
    end

    // working weights change only at a line start
    assert_weights_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        !apply |=> $stable(act));

endmodule

// File: rtl/pxfir_window.sv
module pxfir_window
    import pxfir_pkg::*;
#(
    parameter int TAPS     = 5,
    parameter int IN_W     = 8,
    parameter int GUARD_EN = 1,
    parameter int GUARD_LO = 16,
    parameter int GUARD_HI = 235
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         en,
    input  logic                         in_valid,
    input  logic [IN_W-1:0]              in_data,
    input  logic                         in_eol,
    output logic                         in_ready,
    output logic                         line_start,
    output logic [TAPS-1:0][IN_W-1:0]    win,
    output beat_tag_t                    tag
);

    localparam int H     = half_span(TAPS);
    localparam int CNT_W = $clog2(H + 2);
    localparam logic [CNT_W-1:0] H_C   = CNT_W'(H);
    localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

    win_state_e        st;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  drain_left;
    logic [IN_W-1:0]   pix_c;
    logic              take;

    assign in_ready   = en && (st != WIN_DRAIN);
    assign take       = in_valid && in_ready;
    assign line_start = take && (st == WIN_IDLE);

    generate
        if (GUARD_EN != 0) begin : g_guard
            localparam logic [IN_W-1:0] LO_V = IN_W'(GUARD_LO);
            localparam logic [IN_W-1:0] HI_V = IN_W'(GUARD_HI);
            always_comb begin
                if (in_data < LO_V)      pix_c = LO_V;
                else if (in_data > HI_V) pix_c = HI_V;
                else                     pix_c = in_data;
            end
            // every accepted sample lands inside the guard window
            assert_guard_window_R2: assert property (@(posedge clk) disable iff (rst)
                take |=> (win[0] >= LO_V) && (win[0] <= HI_V));
        end else begin : g_pass
            assign pix_c = in_data;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= WIN_IDLE;
            cnt        <= '0;
            drain_left <= '0;
            win        <= '0;
            tag        <= '0;
        end else if (en) begin
            tag <= '0;
            if (take) begin
                if (st == WIN_IDLE) begin
                    for (int k = 0; k < TAPS; k++) win[k] <= pix_c;
                    cnt <= ONE_C;
                end else begin
                    win[0] <= pix_c;
                    for (int k = 1; k < TAPS; k++) win[k] <= win[k-1];
                    tag.v <= (cnt == H_C);
                    if (cnt != H_C) cnt <= cnt + ONE_C;
                end
                if (in_eol) begin
                    st         <= WIN_DRAIN;
                    drain_left <= H_C;
                end else begin
                    st <= WIN_RUN;
                end
            end else if (st == WIN_DRAIN) begin
                for (int k = 1; k < TAPS; k++) win[k] <= win[k-1];
                tag.v   <= (cnt == H_C);
                tag.eol <= (drain_left == ONE_C);
                if (drain_left == ONE_C) begin
                    st  <= WIN_IDLE;
                    cnt <= '0;
                end else begin
                    drain_left <= drain_left - ONE_C;
                    if (cnt != H_C) cnt <= cnt + ONE_C;
                end
            end
        end
    end

    // accepting a line end closes input for the flush
    assert_eol_closes_input_R8: assert property (@(posedge clk) disable iff (rst)
        (take && in_eol) |=> !in_ready);

endmodule

// File: rtl/pxfir_mac.sv
module pxfir_mac
    import pxfir_pkg::*;
#(
    parameter int TAPS        = 5,
    parameter int IN_W        = 8,
    parameter int COEF_W      = 10,
    parameter int COEF_SIGNED = 1,
    parameter int ACC_W       = 22
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           en,
    input  logic [TAPS-1:0][IN_W-1:0]      win,
    input  logic [TAPS-1:0][COEF_W-1:0]    coef,
    input  beat_tag_t                      tag_in,
    output logic signed [ACC_W-1:0]        acc,
    output beat_tag_t                      tag_out
);

    localparam int PW = IN_W + COEF_W + 2;

    logic signed [PW-1:0]    prod_c [TAPS];
    logic signed [PW-1:0]    prod_q [TAPS];
    logic signed [ACC_W-1:0] sum_c;
    beat_tag_t               tag_mid;

    generate
        for (genvar k = 0; k < TAPS; k++) begin : g_tap
            logic signed [IN_W:0]   px_s;
            logic signed [COEF_W:0] cf_s;
            assign px_s = signed'({1'b0, win[k]});
            if (COEF_SIGNED != 0) begin : g_sgn
                assign cf_s = signed'({coef[k][COEF_W-1], coef[k]});
            end else begin : g_uns
                assign cf_s = signed'({1'b0, coef[k]});
            end
            assign prod_c[k] = PW'(px_s) * PW'(cf_s);
        end
    endgenerate

    always_comb begin
        sum_c = '0;
        for (int k = 0; k < TAPS; k++) begin
            sum_c = sum_c + ACC_W'(prod_q[k]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < TAPS; k++) prod_q[k] <= '0;
            tag_mid <= '0;
            acc     <= '0;
            tag_out <= '0;
        end else if (en) begin
            for (int k = 0; k < TAPS; k++) prod_q[k] <= prod_c[k];
            tag_mid <= tag_in;
            acc     <= sum_c;
            tag_out <= tag_mid;
        end
    end

endmodule

// File: rtl/pxfir_requant.sv
module pxfir_requant
    import pxfir_pkg::*;
#(
    parameter int ACC_W = 22,
    parameter int DROP  = 6,
    parameter int OUT_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic signed [ACC_W-1:0]  acc,
    input  beat_tag_t                tag_in,
    output logic [OUT_W-1:0]         out_q,
    output beat_tag_t                tag_out
);

    localparam int RW = ACC_W + 1;
    localparam logic signed [RW-1:0] MAXV = RW'((2 ** OUT_W) - 1);

    logic signed [RW-1:0] rnd;
    logic [OUT_W-1:0]     sat_c;
    logic                 is_neg;
    logic                 is_big;

    generate
        if (DROP > 0) begin : g_round
            localparam logic signed [RW-1:0] HALF = RW'(2 ** (DROP - 1));
            assign rnd = (RW'(acc) + HALF) >>> DROP;
        end else begin : g_keep
            assign rnd = RW'(acc);
        end
    endgenerate

    assign is_neg = rnd[RW-1];
    assign is_big = !is_neg && (rnd > MAXV);

    always_comb begin
        if (is_neg)      sat_c = '0;
        else if (is_big) sat_c = '1;
        else             sat_c = rnd[OUT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q   <= '0;
            tag_out <= '0;
        end else if (en) begin
            out_q   <= sat_c;
            tag_out <= tag_in;
        end
    end

    assert_negative_to_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (en && tag_in.v && is_neg) |=> (out_q == '0));

    assert_overflow_to_max_R7: assert property (@(posedge clk) disable iff (rst)
        (en && tag_in.v && is_big) |=> (out_q == {OUT_W{1'b1}}));

endmodule

// File: rtl/pix_fir.sv
module pix_fir
    import pxfir_pkg::*;
#(
    parameter int TAPS        = 5,
    parameter int IN_W        = 8,
    parameter int COEF_W      = 10,
    parameter int COEF_SIGNED = 1,
    parameter int COEF_FRAC   = 6,
    parameter int OUT_W       = 8,
    parameter int OUT_FRAC    = 0,
    parameter int GUARD_EN    = 1,
    parameter int GUARD_LO    = 16,
    parameter int GUARD_HI    = 235
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [IN_W-1:0]            in_data,
    input  logic                       in_eol,
    output logic                       in_ready,
    output logic                       out_valid,
    output logic [OUT_W-1:0]           out_data,
    output logic                       out_eol,
    input  logic                       out_ready,
    input  logic                       coef_wr,
    input  logic [$clog2(TAPS)-1:0]    coef_idx,
    input  logic [COEF_W-1:0]          coef_val
);

    localparam int IDX_W = $clog2(TAPS);
    localparam int ACC_W = acc_width(IN_W, COEF_W, TAPS);
    localparam int DROP  = COEF_FRAC - OUT_FRAC;

    logic                          en;
    logic                          line_start;
    logic [TAPS-1:0][IN_W-1:0]     win;
    logic [TAPS-1:0][COEF_W-1:0]   coef_act;
    beat_tag_t                     tag_win;
    beat_tag_t                     tag_acc;
    beat_tag_t                     tag_out;
    logic signed [ACC_W-1:0]       acc;

    assign en        = !out_valid || out_ready;
    assign out_valid = tag_out.v;
    assign out_eol   = tag_out.eol;

    pxfir_coef_bank #(
        .TAPS   (TAPS),
        .COEF_W (COEF_W),
        .IDX_W  (IDX_W)
    ) u_bank (
        .clk   (clk),
        .rst   (rst),
        .wr    (coef_wr),
        .idx   (coef_idx),
        .val   (coef_val),
        .apply (line_start),
        .act   (coef_act)
    );

    pxfir_window #(
        .TAPS     (TAPS),
        .IN_W     (IN_W),
        .GUARD_EN (GUARD_EN),
        .GUARD_LO (GUARD_LO),
        .GUARD_HI (GUARD_HI)
    ) u_win (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_eol     (in_eol),
        .in_ready   (in_ready),
        .line_start (line_start),
        .win        (win),
        .tag        (tag_win)
    );

    pxfir_mac #(
        .TAPS        (TAPS),
        .IN_W        (IN_W),
        .COEF_W      (COEF_W),
        .COEF_SIGNED (COEF_SIGNED),
        .ACC_W       (ACC_W)
    ) u_mac (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .win     (win),
        .coef    (coef_act),
        .tag_in  (tag_win),
        .acc     (acc),
        .tag_out (tag_acc)
    );

    pxfir_requant #(
        .ACC_W (ACC_W),
        .DROP  (DROP),
        .OUT_W (OUT_W)
    ) u_rq (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .acc     (acc),
        .tag_in  (tag_acc),
        .out_q   (out_data),
        .tag_out (tag_out)
    );

    // a stalled output beat holds its contents
    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_eol)));

endmodule

// File: tb/sim_pix_fir.sv
module sim_pix_fir;

    localparam int TAPS = 5;
    localparam int FRAC = 6;
    localparam int H    = 2;
    localparam int LO   = 16;
    localparam int HI   = 235;
    localparam int OMAX = 255;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_eol = 1'b0;
    logic       in_ready;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_eol;
    logic       out_ready = 1'b1;
    logic       coef_wr = 1'b0;
    logic [2:0] coef_idx = '0;
    logic [9:0] coef_val = '0;

    // 125 MHz: 8-unit period with a 1 ns unit
    always #4 clk = ~clk;

    pix_fir u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_eol    (in_eol),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_eol   (out_eol),
        .out_ready (out_ready),
        .coef_wr   (coef_wr),
        .coef_idx  (coef_idx),
        .coef_val  (coef_val)
    );

    int          total = 0;
    int          bad = 0;
    int          cf [TAPS];
    int          lb [64];
    int          exp_d [$];
    bit          exp_e [$];
    string       exp_r [$];
    bit          stall_on = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(input bit ok, input string r, input int got, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d", r, got, expv);
        end
    endtask

    function automatic int clampx(input int v);
        if (v < LO) return LO;
        if (v > HI) return HI;
        return v;
    endfunction

    function automatic int model(input int n, input int i);
        int acc = 0;
        int r;
        for (int k = 0; k < TAPS; k++) begin
            int p = i + H - k;
            if (p < 0) p = 0;
            if (p > n - 1) p = n - 1;
            acc += cf[k] * clampx(lb[p]);
        end
        r = (acc + (1 << (FRAC - 1))) >>> FRAC;
        if (r < 0) r = 0;
        if (r > OMAX) r = OMAX;
        return r;
    endfunction

    task automatic expect_line(input int n, input string r);
        for (int i = 0; i < n; i++) begin
            exp_d.push_back(model(n, i));
            exp_e.push_back(i == n - 1);
            exp_r.push_back(r);
        end
    endtask

    task automatic push_pix(input int v, input bit e);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 8'(v);
        in_eol   = e;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_eol   = 1'b0;
        if (e) begin
            @(negedge clk);
            #1;
            check(!in_ready, "R8 input closed during flush", int'(in_ready), 0);
        end
    endtask

    task automatic drive_part(input int n, input int from, input int to);
        for (int i = from; i < to; i++) push_pix(lb[i], i == n - 1);
    endtask

    task automatic send_line(input int n, input string r);
        expect_line(n, r);
        drive_part(n, 0, n);
    endtask

    task automatic set_coefs(input int c0, input int c1, input int c2, input int c3, input int c4);
        int t [TAPS];
        t = '{c0, c1, c2, c3, c4};
        for (int k = 0; k < TAPS; k++) begin
            @(negedge clk);
            coef_wr  = 1'b1;
            coef_idx = 3'(k);
            coef_val = 10'(t[k]);
            cf[k]    = t[k];
        end
        @(negedge clk);
        coef_wr = 1'b0;
    endtask

    task automatic ramp(input int n, input int base, input int step);
        for (int i = 0; i < n; i++) lb[i] = base + i * step;
    endtask

    // output side: pseudo-random backpressure and comparison
    initial begin
        forever begin
            int    d;
            bit    e;
            string r;
            @(negedge clk);
            if (stall_on) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                out_ready = lfsr[0] | lfsr[3];
            end else begin
                out_ready = 1'b1;
            end
            #1;
            if (!rst && out_valid && out_ready) begin
                if (exp_d.size() == 0) begin
                    check(1'b0, "R8 output with none expected", int'(out_data), -1);
                end else begin
                    d = exp_d.pop_front();
                    e = exp_e.pop_front();
                    r = exp_r.pop_front();
                    check(int'(out_data) == d, r, int'(out_data), d);
                    check(out_eol == e, "R8 line end flag", int'(out_eol), int'(e));
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R9 watchdog expired got=0 exp=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < TAPS; k++) cf[k] = 0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check(!out_valid, "R1 out_valid after reset", int'(out_valid), 0);
        check(in_ready, "R1 in_ready after reset", int'(in_ready), 1);

        // R1: working weights are zero before any write
        ramp(4, 50, 30);
        send_line(4, "R1 zero weights after reset");

        // R2: guard window, identity kernel
        set_coefs(0, 0, 64, 0, 0);
        lb[0] = 0;   lb[1] = 5;   lb[2] = 15;  lb[3] = 16;
        lb[4] = 17;  lb[5] = 100; lb[6] = 200; lb[7] = 234;
        lb[8] = 235; lb[9] = 236; lb[10] = 250; lb[11] = 255;
        send_line(12, "R2 guard clamp");

        // R3: smoothing and a sharpening kernel
        set_coefs(8, 16, 16, 16, 8);
        ramp(12, 16, 19);
        send_line(12, "R3 smoothing");
        set_coefs(-10, 30, 40, 30, -10);
        ramp(12, 230, -18);
        send_line(12, "R3 sharpening");

        // R4: one-sided kernels expose replication at both ends
        set_coefs(64, 0, 0, 0, 0);
        for (int n = 1; n <= 7; n += 2) begin
            ramp(n, 20, 25);
            send_line(n, "R4 right edge");
        end
        ramp(2, 40, 60);
        send_line(2, "R4 right edge two");
        set_coefs(0, 0, 0, 0, 64);
        for (int n = 1; n <= 7; n += 2) begin
            ramp(n, 20, 25);
            send_line(n, "R4 left edge");
        end
        set_coefs(3, -7, 50, 11, 5);
        for (int n = 1; n <= 4; n++) begin
            ramp(n, 90, 37);
            send_line(n, "R4 short line");
        end

        // R5: half values round up
        set_coefs(0, 0, 32, 0, 0);
        ramp(12, 16, 1);
        send_line(12, "R5 half weight");
        set_coefs(0, 0, 96, 0, 0);
        ramp(12, 17, 7);
        send_line(12, "R5 one and a half");

        // R6: negative sums clamp to zero
        set_coefs(-64, 0, 64, 0, 0);
        ramp(10, 20, 20);
        send_line(10, "R6 negative clamp");
        ramp(10, 220, -20);
        send_line(10, "R6 positive side");

        // R7: overflow clamps to the maximum
        set_coefs(0, 0, 200, 0, 0);
        ramp(12, 16, 19);
        send_line(12, "R7 gain overflow");
        set_coefs(100, 100, 100, 100, 100);
        ramp(8, 30, 25);
        send_line(8, "R7 summed overflow");

        // R10: mid-line write waits for the next line
        stall_on = 1'b1;
        set_coefs(0, 0, 64, 0, 0);
        ramp(10, 40, 17);
        expect_line(10, "R10 old set kept");
        drive_part(10, 0, 4);
        set_coefs(0, 0, 128, 0, 0);
        drive_part(10, 4, 10);
        send_line(10, "R10 new set applied");

        // R3 / R9: sweep every input code under random stalls
        set_coefs(-20, 40, 50, 40, -20);
        for (int l = 0; l < 16; l++) begin
            for (int i = 0; i < 16; i++) lb[i] = l * 16 + i;
            send_line(16, "R9 stalled sweep");
        end
        set_coefs(100, -60, 64, -60, 100);
        for (int l = 0; l < 16; l++) begin
            for (int i = 0; i < 16; i++) lb[i] = 255 - (l * 16 + i);
            send_line(16, "R3 alternating sweep");
        end

        repeat (3000) begin
            if (exp_d.size() == 0) break;
            @(negedge clk);
        end
        check(exp_d.size() == 0, "R8 all outputs delivered", exp_d.size(), 0);
        repeat (20) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule